// File: doc/BRIEF.md
# Serial Character Transmitter with Status Flags

This block turns bytes written by a CPU into asynchronous serial frames on one output line. A write port loads a one-character holding register. On a bit-rate enable tick, a separate shift engine takes the held character and sends it least significant bit first. Each frame is one low start bit, 8 or 9 data bits and one high stop bit. The engine can also send an idle preamble, which is a frame time of ones, and break characters, which are frame times of zeros. The rate generator is outside the block and supplies a one-cycle tick per bit time.

Two status flags describe the transmitter. The empty flag says the holding register may take a new character. The done flag says the line has gone quiet with nothing left to send. Each flag drives a level interrupt output gated by its own enable. When the transmitter is switched off in the middle of a character, that character still goes out in full before the line is released.

Top module: `async_tx`

## Requirements
- R1: After reset the line is high, the empty flag is 1 and the done flag is 1. The line is high whenever no frame is being sent.
- R2: A write stores `wdata_i` and clears the empty flag in the next cycle. `empty_irq_o` equals the empty flag ANDed with `empty_ie_i`.
- R3: A held character moves to the shift engine only on a cycle with `bit_tick_i` high, and only while `tx_en_i` is 1. The move sets the empty flag again.
- R4: With `wide_i`=0 a frame is a start bit 0, then `wdata_i[7:0]` least significant bit first, then a stop bit 1. Each bit lasts one tick interval.
- R5: With `wide_i`=1 the frame carries 9 data bits, `wdata_i[8:0]`, least significant bit first, before the stop bit.
- R6: When `tx_en_i` rises, including the first time after reset, one all-ones frame of the current frame length goes out before any data or break.
- R7: While `brk_i` and `tx_en_i` are high, all-zero frames of the frame length are sent back to back. After `brk_i` drops, the current break frame finishes and the line returns high.
- R8: The done flag sets when a frame ends and no new frame starts on that tick. A write or a frame start clears it. `done_irq_o` equals the done flag ANDed with `done_ie_i`.
- R9: If `tx_en_i` drops during a frame, the frame finishes unchanged and the done flag sets. A character still held is not sent and the empty flag stays 0.
- R10: A pending break frame is sent before a held data character.
- R11: If a write lands on the same tick as a transfer, the old character is sent, the new one is held and the empty flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle pulse per bit time |
| tx_en_i | input | 1 | Transmitter enable |
| wide_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| brk_i | input | 1 | Request break frames |
| wr_i | input | 1 | Write strobe for the holding register |
| wdata_i | input | 9 | Character to send |
| empty_ie_i | input | 1 | Enable for the empty interrupt |
| done_ie_i | input | 1 | Enable for the done interrupt |
| txd_o | output | 1 | Serial line, idles high |
| empty_o | output | 1 | Holding register empty flag |
| done_o | output | 1 | Transmission complete flag |
| empty_irq_o | output | 1 | Empty interrupt |
| done_irq_o | output | 1 | Done interrupt |

## Verification
The assertions check the following on every cycle:
- The shift engine moves only on a tick.
- The line is high while no frame is active.
- The holding flag follows writes and transfers.
- The done flag never coexists with an active frame.
- A frame running after disable ends in done unless a write intervenes.

Only the bench scenarios can show the rest: the bit order and framing on the line, the preamble delay after enabling, the break-before-data order, the write that coincides with a transfer, and a held character surviving a disable.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;
  typedef enum logic [1:0] {
    FRM_NONE = 2'd0,
    FRM_PRE  = 2'd1,
    FRM_BRK  = 2'd2,
    FRM_DATA = 2'd3
  } frame_kind_e;
endpackage

// File: rtl/async_tx_hold.sv
module async_tx_hold #(
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              take_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o
);
  logic [DATA_W-1:0] data_q;
  logic              full_q;

  // a write wins over a same-cycle take: old data leaves, new data stays
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else if (wr_i) begin
      data_q <= wdata_i;
      full_q <= 1'b1;
    end else if (take_i) begin
      full_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;

  assert_write_fills_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> full_o);
  assert_take_empties_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !wr_i |=> !full_o);
  assert_take_needs_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> full_o);
endmodule

// File: rtl/async_tx_select.sv
module async_tx_select
  import async_tx_pkg::*;
#(
  parameter int unsigned DATA_W   = 9,
  parameter int unsigned NARROW_W = 8,
  localparam int unsigned FRAME_W = DATA_W + 2,
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               tx_en_i,
  input  logic               pre_req_i,
  input  logic               brk_i,
  input  logic               full_i,
  input  logic               wide_i,
  input  logic [DATA_W-1:0]  data_i,
  output frame_kind_e        kind_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   len_o
);
  localparam int unsigned PAD_W = FRAME_W - NARROW_W - 1;

  logic [FRAME_W-1:0] wide_frm, narrow_frm;

  assign wide_frm   = {1'b1, data_i, 1'b0};
  assign narrow_frm = {{PAD_W{1'b1}}, data_i[NARROW_W-1:0], 1'b0};
  assign len_o      = wide_i ? CNT_W'(FRAME_W) : CNT_W'(NARROW_W + 2);

  // priority: preamble, then break, then held data
  always_comb begin
    kind_o  = FRM_NONE;
    frame_o = '1;
    if (tx_en_i) begin
      if (pre_req_i) begin
        kind_o  = FRM_PRE;
        frame_o = '1;
      end else if (brk_i) begin
        kind_o  = FRM_BRK;
        frame_o = '0;
      end else if (full_i) begin
        kind_o  = FRM_DATA;
        frame_o = wide_i ? wide_frm : narrow_frm;
      end
    end
  end
endmodule

// File: rtl/async_tx_shift.sv
module async_tx_shift
  import async_tx_pkg::*;
#(
  parameter int unsigned FRAME_W = 11,
  localparam int unsigned CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  frame_kind_e        kind_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   len_i,
  output logic               txd_o,
  output logic               active_o,
  output logic               start_o,
  output logic               stop_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               slot_free;

  // slot frees on the tick that ends the last bit, so frames chain gaplessly
  assign slot_free = tick_i && (cnt_q <= CNT_W'(1));
  assign start_o   = slot_free && (kind_i != FRM_NONE);
  assign stop_o    = tick_i && (cnt_q == CNT_W'(1)) && (kind_i == FRM_NONE);
  assign active_o  = (cnt_q != '0);
  assign txd_o     = active_o ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '1;
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q > CNT_W'(1)) begin
        sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
        cnt_q <= cnt_q - CNT_W'(1);
      end else if (kind_i != FRM_NONE) begin
        sh_q  <= frame_i;
        cnt_q <= len_i;
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assert_step_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q) && $stable(sh_q));
  assert_idle_line_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> txd_o);
  assert_len_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(FRAME_W));
endmodule

// File: rtl/async_tx.sv
module async_tx
  import async_tx_pkg::*;
#(
  parameter int unsigned DATA_W   = 9,
  parameter int unsigned NARROW_W = 8,
  localparam int unsigned FRAME_W = DATA_W + 2,
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_tick_i,
  input  logic              tx_en_i,
  input  logic              wide_i,
  input  logic              brk_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              empty_ie_i,
  input  logic              done_ie_i,
  output logic              txd_o,
  output logic              empty_o,
  output logic              done_o,
  output logic              empty_irq_o,
  output logic              done_irq_o
);
  logic               en_q, pre_q, pre_req, done_q;
  logic               full, take, active, start, stop;
  logic [DATA_W-1:0]  hold_data;
  frame_kind_e        kind;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   len;

  assign pre_req = tx_en_i && (pre_q || !en_q);
  assign take    = start && (kind == FRM_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pre_q  <= 1'b0;
      done_q <= 1'b1;
    end else begin
      en_q  <= tx_en_i;
      pre_q <= pre_req && !(start && kind == FRM_PRE);
      if (start || wr_i) done_q <= 1'b0;
      else if (stop)     done_q <= 1'b1;
    end
  end

  async_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .take_i  (take),
    .data_o  (hold_data),
    .full_o  (full)
  );

  async_tx_select #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_sel (
    .tx_en_i   (tx_en_i),
    .pre_req_i (pre_req),
    .brk_i     (brk_i),
    .full_i    (full),
    .wide_i    (wide_i),
    .data_i    (hold_data),
    .kind_o    (kind),
    .frame_o   (frame),
    .len_o     (len)
  );

  async_tx_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (bit_tick_i),
    .kind_i   (kind),
    .frame_i  (frame),
    .len_i    (len),
    .txd_o    (txd_o),
    .active_o (active),
    .start_o  (start),
    .stop_o   (stop)
  );

  assign empty_o     = !full;
  assign done_o      = done_q;
  assign empty_irq_o = empty_o && empty_ie_i;
  assign done_irq_o  = done_o && done_ie_i;

  assert_done_means_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !active);
  assert_disable_finishes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active && !tx_en_i |=> active || done_o || $past(wr_i));
  assert_no_data_while_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |-> !start);
endmodule

// File: tb/async_tx_bench.sv
module async_tx_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tx_en = 1'b0, wide = 1'b0, brk = 1'b0, wr = 1'b0;
  logic [8:0] wdata = '0;
  logic       empty_ie = 1'b0, done_ie = 1'b0;
  logic       txd, empty, done, empty_irq, done_irq;
  logic [2:0] tick_cnt = '0;
  logic       tick;
  int         tests = 0, fails = 0;

  always #5 clk = ~clk;
  always @(negedge clk) tick_cnt <= tick_cnt + 3'd1;
  assign tick = (tick_cnt == 3'd0);

  async_tx u_async_tx (
    .clk_i (clk), .rst_ni (rst_ni), .bit_tick_i (tick), .tx_en_i (tx_en),
    .wide_i (wide), .brk_i (brk), .wr_i (wr), .wdata_i (wdata),
    .empty_ie_i (empty_ie), .done_ie_i (done_ie), .txd_o (txd),
    .empty_o (empty), .done_o (done), .empty_irq_o (empty_irq), .done_irq_o (done_irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_fall(output int t);
    t = 0;
    while (txd === 1'b1 && t < 3000) begin @(negedge clk); t++; end
  endtask

  task automatic sample(input int n, input int first, output logic [31:0] v);
    v = '0;
    repeat (first) @(negedge clk);
    v[0] = txd;
    for (int i = 1; i < n; i++) begin
      repeat (8) @(negedge clk);
      v[i] = txd;
    end
  endtask

  task automatic write(input logic [8:0] d);
    wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic settle();
    int t = 0;
    while (!(done === 1'b1) && t < 3000) begin @(negedge clk); t++; end
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(txd === 1'b1, "R1 idle line", txd, 1);
    chk(empty === 1'b1 && done === 1'b1, "R1 flags", {empty, done}, 2'b11);
    chk(empty_irq === 1'b0 && done_irq === 1'b0, "R2 R8 masked irqs", {empty_irq, done_irq}, 0);
    empty_ie = 1'b1; done_ie = 1'b1;
    #1;
    chk(empty_irq === 1'b1 && done_irq === 1'b1, "R2 R8 enabled irqs", {empty_irq, done_irq}, 2'b11);
    @(negedge clk);
    tx_en = 1'b1;
    settle();
  endtask

  task automatic t_basic8();
    logic [31:0] v; int t;
    write(9'h0A5);
    chk(empty === 1'b0 && empty_irq === 1'b0, "R2 write clears empty", {empty, empty_irq}, 0);
    chk(done === 1'b0, "R8 write clears done", done, 0);
    wait_fall(t);
    sample(10, 4, v);
    chk(v[0] === 1'b0 && v[9] === 1'b1, "R4 start/stop", {v[9], v[0]}, 2'b10);
    chk(v[8:1] === 8'hA5, "R4 data lsb first", v[8:1], 8'hA5);
    chk(empty === 1'b1 && empty_irq === 1'b1, "R3 transfer sets empty", {empty, empty_irq}, 2'b11);
    repeat (16) @(negedge clk);
    chk(done === 1'b1 && done_irq === 1'b1, "R8 done after frame", {done, done_irq}, 2'b11);
  endtask

  task automatic t_wide9();
    logic [31:0] v; int t;
    wide = 1'b1;
    write(9'h1C3);
    wait_fall(t);
    sample(11, 4, v);
    chk(v[9:1] === 9'h1C3 && v[10] === 1'b1, "R5 nine data bits", v[10:0], {1'b1, 9'h1C3, 1'b0});
    settle();
    wide = 1'b0;
  endtask

  task automatic t_tick_sync();
    logic [31:0] v; int t;
    do @(posedge clk); while (tick_cnt != 3'd0);
    @(negedge clk);
    write(9'h03C);
    repeat (4) @(negedge clk);
    chk(empty === 1'b0, "R3 no transfer between ticks", empty, 0);
    wait_fall(t);
    sample(10, 4, v);
    chk(v[8:1] === 8'h3C, "R3 data after tick", v[8:1], 8'h3C);
    settle();
  endtask

  task automatic t_overlap();
    logic [31:0] v; int t;
    do @(posedge clk); while (tick_cnt != 3'd3);
    @(negedge clk);
    write(9'h012);
    do @(posedge clk); while (tick_cnt != 3'd7);
    @(negedge clk);
    write(9'h0E7);
    chk(empty === 1'b0, "R11 new byte held", empty, 0);
    wait_fall(t);
    sample(20, 4, v);
    chk(v[8:1] === 8'h12, "R11 old byte sent first", v[8:1], 8'h12);
    chk(v[10] === 1'b0 && v[18:11] === 8'hE7 && v[19] === 1'b1, "R11 new byte follows", v[19:10], {1'b1, 8'hE7, 1'b0});
    settle();
  endtask

  task automatic t_break();
    logic [31:0] v; int t;
    brk = 1'b1;
    write(9'h03C);
    wait_fall(t);
    brk = 1'b0;
    sample(20, 4, v);
    chk(v[9:0] === 10'h000, "R7 break frame zeros", v[9:0], 0);
    chk(v[18:11] === 8'h3C && v[19] === 1'b1, "R10 data after break", v[19:11], {1'b1, 8'h3C});
    settle();
    brk = 1'b1;
    wait_fall(t);
    sample(15, 4, v);
    chk(v[14:0] === 15'h0000, "R7 breaks back to back", v[14:0], 0);
    brk = 1'b0;
    repeat (64) @(negedge clk);
    chk(txd === 1'b1 && done === 1'b1, "R7 line high after break", {txd, done}, 2'b11);
    settle();
  endtask

  task automatic t_disable();
    logic [31:0] v; int t; bit low_seen;
    write(9'h05A);
    wait_fall(t);
    wr = 1'b1; wdata = 9'h099; tx_en = 1'b0;
    @(negedge clk);
    wr = 1'b0;
    sample(10, 3, v);
    chk(v[8:1] === 8'h5A && v[9] === 1'b1 && v[0] === 1'b0, "R9 frame completes", v[9:0], {1'b1, 8'h5A, 1'b0});
    low_seen = 1'b0;
    repeat (240) begin @(negedge clk); if (txd !== 1'b1) low_seen = 1'b1; end
    chk(!low_seen, "R9 line released high", low_seen, 0);
    chk(empty === 1'b0 && done === 1'b1, "R9 byte kept, done set", {empty, done}, 2'b01);
    tx_en = 1'b1;
    wait_fall(t);
    chk(t >= 80 && t < 100, "R6 preamble delay", t, 80);
    sample(10, 4, v);
    chk(v[8:1] === 8'h99, "R6 held byte after preamble", v[8:1], 8'h99);
    settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic8();
    t_wide9();
    t_tick_sync();
    t_overlap();
    t_break();
    t_disable();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule